// File: doc/BRIEF.md
# Half-Precision Pair to Single-Precision Unpacker

This block accepts a 32-bit word that carries two IEEE 754 binary16 values and widens each one to an IEEE 754 binary32 bit pattern. Every binary16 value is exactly representable in binary32, so the conversion never rounds. Each lane sorts its half value into one of five classes (zero, subnormal, normal, infinity, NaN) by looking at its exponent and fraction fields. It then builds the wide exponent and fraction and copies the sign into bit 31.

The lane logic is purely combinational. A single register stage sits behind it and loads only when the input qualifier is high, so a result appears one clock after its word is presented. Half subnormals become binary32 normals after a leading-one search. Every NaN comes out as one fixed quiet pattern, and its payload is not carried over.

Top module: `hp_pair_unpack`

## Requirements
- R1: Lane 0 converts input bits 15:0 and drives output bits 31:0. Lane 1 converts input bits 31:16 and drives output bits 63:32.
- R2: A half value with exponent field (bits 14:10) from 1 to 30 produces a binary32 exponent equal to that field plus 112, and a fraction equal to the half fraction (bits 9:0) shifted left by 13.
- R3: A half value with zero exponent and zero fraction produces 0x00000000, or 0x80000000 when its sign is set.
- R4: A half value with zero exponent and non-zero fraction f equals f times 2^-24 as a normal binary32. If the highest set bit of f is at position p, the exponent is 103+p and the fraction holds the bits of f below p, left-aligned in the 23-bit field.
- R5: Exponent field 31 with a zero fraction produces 0x7F800000, with the sign in bit 31.
- R6: Exponent field 31 with a non-zero fraction produces 0x7FFFFFFF whatever the payload, with the sign in bit 31.
- R7: Output bit 31 of each lane equals bit 15 of that lane's half value, in every class.
- R8: The result for a word presented with in_valid high appears on out_word one clock later. out_valid is in_valid delayed by one clock.
- R9: While in_valid is low, out_word keeps its previous value no matter what in_word carries.
- R10: During and right after reset, out_valid is 0 and out_word is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies in_word; loads the output register |
| in_word | input | 32 | Two binary16 values, lane 0 in the low half |
| out_valid | output | 1 | Result on out_word is new this cycle |
| out_word | output | 64 | Two binary32 results, lane 0 in the low word |

## Verification
Directed words cover each class boundary. These include signed zeros, the smallest and largest subnormals (leading one at position 0 and at position 9), exponent 1 and 30 normals, both infinities, and NaNs with small and full payloads. A wrong bias, a wrong shift or an off-by-one in the leading-one search each shows up at a different one of these points. The two halves of each word get different classes, so a lane swap or a lane-to-lane leak is visible. Random words then cover the fraction bits broadly. Idle cycles with a changing input word confirm that the output register holds.

// File: rtl/hp_unpack_pkg.sv
package hp_unpack_pkg;
    localparam int HALF_W    = 16;
    localparam int SGL_W     = 32;
    localparam int H_EXP_W   = 5;
    localparam int H_FRAC_W  = 10;
    localparam int S_EXP_W   = 8;
    localparam int S_FRAC_W  = 23;
    localparam int BIAS_GAP  = 112;
    localparam int SUB_BASE  = BIAS_GAP - H_FRAC_W + 1;
    localparam int IDX_W     = $clog2(H_FRAC_W);

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUB,
        CLS_NORM,
        CLS_INF,
        CLS_NAN
    } hp_class_e;
endpackage

// File: rtl/hp_lead_one.sv
module hp_lead_one #(
    parameter int W     = 10,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     vec,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/hp_lane_expand.sv
module hp_lane_expand
    import hp_unpack_pkg::*;
(
    input  logic [HALF_W-1:0] half_in,
    output logic [SGL_W-1:0]  sgl_out
);
    localparam logic [H_EXP_W-1:0]  H_EXP_MAX = '1;
    localparam logic [SGL_W-2:0]    MAG_INF   = {{S_EXP_W{1'b1}}, {S_FRAC_W{1'b0}}};
    localparam logic [SGL_W-2:0]    MAG_NAN   = '1;
    localparam int                  SH_W      = S_FRAC_W + 1;

    logic                  sign_w;
    logic [H_EXP_W-1:0]    exp_w;
    logic [H_FRAC_W-1:0]   frac_w;
    logic [IDX_W-1:0]      lead_w;
    logic [SH_W-1:0]       aligned_w;
    hp_class_e             cls_w;
    logic [SGL_W-2:0]      mag_w;

    assign sign_w = half_in[HALF_W-1];
    assign exp_w  = half_in[HALF_W-2 -: H_EXP_W];
    assign frac_w = half_in[H_FRAC_W-1:0];

    hp_lead_one #(.W(H_FRAC_W), .IDX_W(IDX_W)) u_lead (
        .vec (frac_w),
        .idx (lead_w)
    );

    always_comb begin
        if (exp_w == '0)            cls_w = (frac_w == '0) ? CLS_ZERO : CLS_SUB;
        else if (exp_w == H_EXP_MAX) cls_w = (frac_w == '0) ? CLS_INF : CLS_NAN;
        else                         cls_w = CLS_NORM;
    end

    always_comb begin
        aligned_w = SH_W'(frac_w) << (5'(S_FRAC_W) - 5'(lead_w));
        case (cls_w)
            CLS_ZERO: mag_w = '0;
            CLS_SUB:  mag_w = {S_EXP_W'(SUB_BASE) + S_EXP_W'(lead_w),
                               aligned_w[S_FRAC_W-1:0]};
            CLS_NORM: mag_w = {S_EXP_W'(exp_w) + S_EXP_W'(BIAS_GAP),
                               frac_w, {(S_FRAC_W-H_FRAC_W){1'b0}}};
            CLS_INF:  mag_w = MAG_INF;
            default:  mag_w = MAG_NAN;
        endcase
        sgl_out = {sign_w, mag_w};
    end
endmodule

// File: rtl/hp_pair_unpack.sv
module hp_pair_unpack
    import hp_unpack_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [LANES*HALF_W-1:0] in_word,
    output logic                   out_valid,
    output logic [LANES*SGL_W-1:0] out_word
);
    typedef struct packed {
        logic                          valid;
        logic [LANES-1:0][SGL_W-1:0]   res;
    } stage_t;

    stage_t                        stage_d, stage_q;
    logic [LANES-1:0][SGL_W-1:0]   lane_res;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        hp_lane_expand u_lane (
            .half_in (in_word[g*HALF_W +: HALF_W]),
            .sgl_out (lane_res[g])
        );

        // R7: sign carried through from the half value
        a_r7_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_word[g*SGL_W+SGL_W-1] == $past(in_word[g*HALF_W+HALF_W-1]));

        // R5: infinity maps to the wide infinity magnitude
        a_r5_inf_mag: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_word[g*HALF_W+10 +: 5] == 5'h1F && in_word[g*HALF_W +: 10] == '0)
            |=> out_word[g*SGL_W +: 31] == 31'h7F800000);

        // R6: NaN payloads collapse to one quiet pattern
        a_r6_nan_canon: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_word[g*HALF_W+10 +: 5] == 5'h1F && in_word[g*HALF_W +: 10] != '0)
            |=> out_word[g*SGL_W +: 31] == 31'h7FFFFFFF);

        // R2: normal exponent is rebiased by 112
        a_r2_norm_exp: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_word[g*HALF_W+10 +: 5] != 5'h00 && in_word[g*HALF_W+10 +: 5] != 5'h1F)
            |=> out_word[g*SGL_W+23 +: 8] == 8'($past(in_word[g*HALF_W+10 +: 5])) + 8'd112);
    end

    always_comb begin
        stage_d       = stage_q;
        stage_d.valid = in_valid;
        if (in_valid) stage_d.res = lane_res;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign out_valid = stage_q.valid;
    assign out_word  = stage_q.res;

    // R8: qualifier delayed by exactly one clock
    a_r8_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r8_idle_delay: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9: output held while no word is presented
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_word));
endmodule

// File: tb/hp_pair_unpack_test.sv
`timescale 1ns/1ps
module hp_pair_unpack_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic [63:0] out_word;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hp_pair_unpack uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_word(in_word), .out_valid(out_valid), .out_word(out_word)
    );

    // Reference: normalise by repeated shifting rather than a priority search
    function automatic logic [31:0] ref_conv(input logic [15:0] h);
        logic [4:0]  e;
        logic [10:0] m;
        int          k;
        logic [31:0] r;
        e = h[14:10];
        m = {1'b0, h[9:0]};
        if (e == 5'd31)      r = (m == 0) ? 32'h7F800000 : 32'h7FFFFFFF;
        else if (e != 5'd0)  r = {1'b0, 8'(int'(e) + 112), m[9:0], 13'b0};
        else if (m == 0)     r = 32'h0;
        else begin
            k = 0;
            while (m[10] == 1'b0) begin
                m = m << 1;
                k++;
            end
            r = {1'b0, 8'(113 - k), m[9:0], 13'b0};
        end
        r[31] = h[15];
        return r;
    endfunction

    function automatic string req_of(input logic [15:0] h);
        if (h[14:10] == 5'd31) return (h[9:0] == 0) ? "R5" : "R6";
        if (h[14:10] != 5'd0)  return "R2";
        return (h[9:0] == 0) ? "R3" : "R4";
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    // Present one word, then sample after the capturing edge
    task automatic apply(input logic [31:0] w, input logic [31:0] exp_lo, input logic [31:0] exp_hi,
                         input bit use_exp);
        logic [31:0] e0, e1;
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        @(negedge clk);
        e0 = use_exp ? exp_lo : ref_conv(w[15:0]);
        e1 = use_exp ? exp_hi : ref_conv(w[31:16]);
        check("R8 valid", {63'b0, out_valid}, 64'd1);
        check({req_of(w[15:0]), " R1 R7 lane0"}, {32'b0, out_word[31:0]}, {32'b0, e0});
        check({req_of(w[31:16]), " R1 R7 lane1"}, {32'b0, out_word[63:32]}, {32'b0, e1});
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        logic [31:0] w;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R10 valid", {63'b0, out_valid}, 64'd0);
        check("R10 word", out_word, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 after release", {out_valid, out_word[62:0]}, 64'd0);

        // Directed corners with hand-derived values
        apply(32'h8000_0000, 32'h0000_0000, 32'h8000_0000, 1'b1); // R3 signed zeros
        apply(32'h03FF_0001, 32'h3380_0000, 32'h387F_C000, 1'b1); // R4 smallest/largest sub
        apply(32'h7BFF_3C00, 32'h3F80_0000, 32'h477F_E000, 1'b1); // R2 one and max normal
        apply(32'h0400_8001, 32'hB380_0000, 32'h3880_0000, 1'b1); // R4/R2 boundary, R7
        apply(32'hFC00_7C00, 32'h7F80_0000, 32'hFF80_0000, 1'b1); // R5 both infinities
        apply(32'hFE01_7C01, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1); // R6 payloads discarded
        apply(32'h7FFF_0200, 32'h3800_0000, 32'h7FFF_FFFF, 1'b1); // R4 mid sub, R6 full payload
        apply(32'h3C00_0000, 32'h0000_0000, 32'h3F80_0000, 1'b1); // R1 lanes not swapped

        // R9: idle cycles with changing input must not move the outputs
        held = out_word;
        @(negedge clk);
        in_valid = 1'b0;
        in_word  = 32'hDEAD_BEEF;
        @(negedge clk);
        check("R8 idle valid", {63'b0, out_valid}, 64'd0);
        check("R9 hold", out_word, held);
        in_word = 32'h1234_5678;
        @(negedge clk);
        check("R9 hold again", out_word, held);

        // Random words, with occasional idle gaps
        for (int i = 0; i < 400; i++) begin
            w = $urandom;
            apply(w, 32'h0, 32'h0, 1'b0);
            if ((i % 37) == 0) begin
                held = out_word;
                @(negedge clk);
                in_valid = 1'b0;
                in_word  = $urandom;
                @(negedge clk);
                check("R9 random hold", out_word, held);
            end
        end

        // R10: reset mid-stream clears the stage
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b0;
        @(negedge clk);
        check("R10 mid reset", {out_valid, out_word[62:0]}, 64'd0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule